// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single burst request into a stream of column addresses for a synchronous DRAM controller. The request gives a starting column, a length code and an ordering flag. The block then emits one column address per accepted beat. Lengths of 1, 2, 4 and 8 beats are supported, along with an open-ended full-page burst. The order is either sequential, which counts up and wraps inside the aligned block, or interleaved, which XORs the beat index into the low address bits.

The address stream is a valid/ready interface. A beat is consumed on every rising edge where `col_valid` and `col_ready` are both high. While `col_ready` is low, the presented address and its last flag stay frozen, and the beat index does not advance. `col_valid` never waits on `col_ready`. The control inputs (`start`, `term`) are plain pulses and are obeyed whatever the state of `col_ready`.

Data movement, access-latency delays and command generation belong to neighbouring blocks.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `col_valid` and `col_last` are 0 and `col_addr` is 0.
- R2: A `start` sampled at a rising edge makes `col_valid` 1 after that edge, with `col_addr` equal to the sampled `start_col` (beat 0).
- R3: With `ileave`=0 and a fixed length L, beat k shows the bits inside the aligned L-block as (start + k) mod L. For example, start 5 with L=8 gives 5,6,7,0,1,2,3,4.
- R4: With `ileave`=1 and a fixed length L, the bits inside the L-block are the start bits XOR k. For example, start 5 with L=8 gives 5,4,7,6,1,0,3,2.
- R5: Address bits above the L-block keep the value of `start_col` for every beat of a fixed-length burst. With L=4 only bits 1..0 change, and with L=2 only bit 0 changes.
- R6: `col_last` is 1 exactly on beat L-1 of a fixed-length burst. When that beat is accepted, `col_valid` goes to 0 unless `start` is also present.
- R7: While `col_valid`=1 and `col_ready`=0, with no `start` or `term`, the values of `col_valid`, `col_addr` and `col_last` stay unchanged.
- R8: A `term` without `start` clears `col_valid` after the edge. While no burst is active, `col_addr` keeps the last value it presented.
- R9: Length code 3'b111 selects full page. The address counts up modulo 512 across the whole column space, `col_last` is never 1, `ileave` is ignored, and the burst runs until `term` or `start`.
- R10: A `start` during an active burst, including one in the same cycle as `term`, abandons the old burst and begins the new one with the new parameters.
- R11: Length codes are 3'b000=1, 3'b001=2, 3'b010=4 and 3'b011=8. The unused codes 3'b100 to 3'b110 behave as length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: begin a burst with the parameters below |
| start_col | input | 9 | Starting column address |
| len_sel | input | 3 | Burst length code (see R11, R9) |
| ileave | input | 1 | 1 = interleaved order, 0 = sequential |
| term | input | 1 | Pulse: end the current burst early |
| col_ready | input | 1 | Consumer accepts the presented address |
| col_valid | output | 1 | A column address is presented |
| col_addr | output | 9 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
Two functions can fall in the same cycle. The first pair is early termination and the launch of a new burst. The bench raises `term` and `start` on the same edge in the middle of an 8-beat burst. It then judges that the new start column and its interleaved successor appear, not an idle stream. The second overlap is back-pressure on the final beat. Holding `col_ready` low while `col_last` is shown must keep both the flag and the address in place until the beat is finally taken.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int COL_W = 9;
  localparam int LEN_W = 3;

  typedef enum logic [LEN_W-1:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_pkg::*;
#(
  parameter int AW = COL_W
) (
  input  logic [LEN_W-1:0] code,
  output logic [AW-1:0]    mask,
  output logic             full
);
  always_comb begin
    mask = '0;
    full = 1'b0;
    case (code)
      LEN_2:    mask = AW'(1);
      LEN_4:    mask = AW'(3);
      LEN_8:    mask = AW'(7);
      LEN_PAGE: begin
        mask = '1;
        full = 1'b1;
      end
      default:  mask = '0;
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [AW-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n)       beat <= '0;
    else if (clear)   beat <= '0;
    else if (advance) beat <= beat + AW'(1);
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int AW = 9
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] beat,
  input  logic [AW-1:0] mask,
  input  logic          ileave,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] seq_sum;
  logic [AW-1:0] xor_val;

  assign seq_sum = base + beat;
  assign xor_val = base ^ beat;

  for (genvar b = 0; b < AW; b++) begin : g_bit
    always_comb begin
      if (!mask[b])   addr[b] = base[b];
      else if (ileave) addr[b] = xor_val[b];
      else            addr[b] = seq_sum[b];
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int AW = COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_col,
  input  logic [LEN_W-1:0] len_sel,
  input  logic             ileave,
  input  logic             term,
  input  logic             col_ready,
  output logic             col_valid,
  output logic [AW-1:0]    col_addr,
  output logic             col_last
);
  logic [AW-1:0] dec_mask;
  logic          dec_full;
  logic          active_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] mask_q;
  logic          il_q;
  logic          full_q;
  logic [AW-1:0] beat;
  logic          fire;
  logic          at_last;

  burst_len_decode #(.AW(AW)) u_dec (
    .code (len_sel),
    .mask (dec_mask),
    .full (dec_full)
  );

  assign at_last = active_q && !full_q && (beat == mask_q);
  assign fire    = active_q && col_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
      il_q     <= 1'b0;
      full_q   <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      base_q   <= start_col;
      mask_q   <= dec_mask;
      il_q     <= ileave && !dec_full;
      full_q   <= dec_full;
    end else if (term) begin
      active_q <= 1'b0;
    end else if (fire && at_last) begin
      active_q <= 1'b0;
    end
  end

  burst_beat_ctr #(.AW(AW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .advance (fire && !at_last && !term),
    .beat    (beat)
  );

  burst_addr_map #(.AW(AW)) u_map (
    .base   (base_q),
    .beat   (beat),
    .mask   (mask_q),
    .ileave (il_q),
    .addr   (col_addr)
  );

  assign col_valid = active_q;
  assign col_last  = at_last;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] start_col,
  input logic [2:0]    len_sel,
  input logic          term,
  input logic          col_ready,
  input logic          col_valid,
  input logic [AW-1:0] col_addr,
  input logic          col_last
);
  AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n) start |=> col_valid); // R2
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n) start |=> col_addr == $past(start_col)); // R2
  AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rst_n) (col_valid && col_ready && col_last && !start) |=> !col_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (col_valid && !col_ready && !start && !term) |=> (col_valid && $stable(col_addr) && $stable(col_last))); // R7
  AST_TERM_STOP: assert property (@(posedge clk) disable iff (!rst_n) (term && !start) |=> !col_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!col_valid && !start) |=> $stable(col_addr)); // R8
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n) (start && len_sel == 3'b111) |=> !col_last); // R9
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) col_last |-> col_valid); // R6
endmodule

bind burst_col_gen burst_col_gen_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_col (start_col),
  .len_sel   (len_sel),
  .term      (term),
  .col_ready (col_ready),
  .col_valid (col_valid),
  .col_addr  (col_addr),
  .col_last  (col_last)
);

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic [2:0] len_sel = '0;
  logic       ileave = 1'b0;
  logic       term = 1'b0;
  logic       col_ready = 1'b1;
  logic       col_valid;
  logic [8:0] col_addr;
  logic       col_last;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  burst_col_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_sel(len_sel), .ileave(ileave), .term(term), .col_ready(col_ready),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
  );

  // fields: col[89:81] len[80:78] il[77] nbeats[76:73] full[72] exp[71:0], beat0 first
  localparam logic [89:0] VEC [0:8] = '{
    {9'h005, 3'b011, 1'b0, 4'd8, 1'b0, 9'h005,9'h006,9'h007,9'h000,9'h001,9'h002,9'h003,9'h004}, // R3
    {9'h005, 3'b011, 1'b1, 4'd8, 1'b0, 9'h005,9'h004,9'h007,9'h006,9'h001,9'h000,9'h003,9'h002}, // R4
    {9'h0B5, 3'b010, 1'b0, 4'd4, 1'b0, 9'h0B5,9'h0B6,9'h0B7,9'h0B4,9'h000,9'h000,9'h000,9'h000}, // R5
    {9'h0B5, 3'b010, 1'b1, 4'd4, 1'b0, 9'h0B5,9'h0B4,9'h0B7,9'h0B6,9'h000,9'h000,9'h000,9'h000}, // R5
    {9'h122, 3'b001, 1'b0, 4'd2, 1'b0, 9'h122,9'h123,9'h000,9'h000,9'h000,9'h000,9'h000,9'h000}, // R5
    {9'h0AA, 3'b000, 1'b0, 4'd1, 1'b0, 9'h0AA,9'h000,9'h000,9'h000,9'h000,9'h000,9'h000,9'h000}, // R11
    {9'h1FE, 3'b111, 1'b1, 4'd5, 1'b1, 9'h1FE,9'h1FF,9'h000,9'h001,9'h002,9'h000,9'h000,9'h000}, // R9
    {9'h047, 3'b101, 1'b0, 4'd1, 1'b0, 9'h047,9'h000,9'h000,9'h000,9'h000,9'h000,9'h000,9'h000}, // R11
    {9'h1FB, 3'b011, 1'b1, 4'd8, 1'b0, 9'h1FB,9'h1FA,9'h1F9,9'h1F8,9'h1FF,9'h1FE,9'h1FD,9'h1FC}  // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [8:0] c, input logic [2:0] l, input logic il);
    start = 1'b1; start_col = c; len_sel = l; ileave = il;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", col_valid, 0);
    chk("R1 addr in reset", col_addr, 0);
    chk("R1 last in reset", col_last, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", col_valid, 0);

    // table walk
    for (int v = 0; v < 9; v++) begin
      logic [89:0] e;
      int nb;
      e = VEC[v];
      nb = int'(e[76:73]);
      launch(e[89:81], e[80:78], e[77]);
      for (int i = 0; i < nb; i++) begin
        chk("R2 valid beat", col_valid, 1);
        chk("R3 R4 R5 R9 addr", col_addr, int'(e[(7-i)*9 +: 9]));
        chk("R6 R9 last", col_last, int'((i == nb-1) && !e[72]));
        if (i < nb-1) @(negedge clk);
      end
      if (e[72]) term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      chk("R6 R8 valid after burst", col_valid, 0);
      @(negedge clk);
    end

    // R7 stall, including on the last beat
    col_ready = 1'b0;
    launch(9'h0B5, 3'b010, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 stall valid", col_valid, 1);
    chk("R7 stall addr", col_addr, 9'h0B5);
    col_ready = 1'b1;
    @(negedge clk);
    chk("R7 resume addr", col_addr, 9'h0B6);
    @(negedge clk);
    @(negedge clk);
    col_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 stall on last addr", col_addr, 9'h0B4);
    chk("R7 stall on last flag", col_last, 1);
    col_ready = 1'b1;
    @(negedge clk);
    chk("R6 done after stalled last", col_valid, 0);

    // R8 early stop, address holds
    launch(9'h010, 3'b011, 1'b0);
    @(negedge clk);
    chk("R8 pre-term addr", col_addr, 9'h011);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk("R8 term valid", col_valid, 0);
    repeat (2) @(negedge clk);
    chk("R8 idle addr hold", col_addr, 9'h011);

    // R10 start and term together mid-burst
    launch(9'h000, 3'b011, 1'b0);
    @(negedge clk);
    term = 1'b1;
    launch(9'h105, 3'b001, 1'b1);
    term = 1'b0;
    chk("R10 restart valid", col_valid, 1);
    chk("R10 restart addr", col_addr, 9'h105);
    @(negedge clk);
    chk("R10 second beat", col_addr, 9'h104);
    chk("R10 last", col_last, 1);
    @(negedge clk);
    chk("R10 end", col_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule